// File: doc/BRIEF.md
# Supply Monitor and Reset Sequencer

This block turns three supply comparator flags into the system's power-fail actions. It takes the flags for supply below the warning level, supply below the minimum operating level, and supply below the backup-cell level. It raises an early power-fail interrupt request and holds the processor in reset. It pulls an open-drain reset pin low, forces the external memory strobes inactive, and drives an active-low indicator that backup power is in use. All comparator flags and external pins are asynchronous, so they first pass through a two-flop synchroniser.

The processor is released from reset a fixed 21504 clock cycles after the supply climbs back above the minimum level, or after the block's own reset is released. The reset pin is bidirectional. Any device on the shared net can pull it low, and every device then holds its processor in reset, so that several parts leave reset together. A separate active-high reset input also forces reset. The bootstrap request pin is qualified with a 48-clock filter in both directions, and only a qualified falling level starts the loader.

Top module: `pwr_supervisor`

## Requirements
- R1: Each flag or pin input is sampled through two flip-flops. A change applied between clock edges reaches the outputs after the second rising edge and not before.
- R2: `pwr_fail_no` is 0 while the synchronised backup-cell flag is 1, and 1 otherwise.
- R3: A rising edge of the synchronised warning flag sets `irq_o` only when `warn_en_i` is 1. A warning level that stays high does not set it again after it has been cleared.
- R4: `irq_ack_i` clears `irq_o` on the next edge. If a new warning edge occurs in the same cycle as an acknowledge, the interrupt is set.
- R5: `irq_vec_o` always carries the interrupt entry address, 16'h002B.
- R6: While the synchronised minimum-level flag is 1, `cpu_rst_o`, `rst_pin_oe_o` and `strobe_block_o` are all 1.
- R7: After the synchronised minimum-level flag falls, `rst_pin_oe_o` and `strobe_block_o` drop at once. `cpu_rst_o` stays 1 for exactly POR_CYCLES (21504) further rising edges.
- R8: A low on `rst_pin_i` holds `cpu_rst_o` at 1 while the pin is low. `cpu_rst_o` releases two edges after the pin returns high, with no power-on delay. The block never drives the pin because of this external low.
- R9: `ext_rst_i` at 1 holds `cpu_rst_o` at 1 with the same synchronised timing as R8, and no delay follows it.
- R10: `boot_act_o` becomes 1 only after the synchronised `boot_req_ni` has been 0 for 48 consecutive samples. It becomes 0 only after 48 consecutive high samples. Shorter pulses are ignored.
- R11: `boot_start_o` is a one-cycle pulse in the cycle `boot_act_o` rises. A qualified return to high produces no pulse.
- R12: While `rst_ni` is 0: `cpu_rst_o`=1, `irq_o`=0, `pwr_fail_no`=1 and `boot_act_o`=0. After release, `cpu_rst_o` stays 1 for POR_CYCLES rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| warn_flag_i | input | 1 | Comparator: supply below warning level |
| min_flag_i | input | 1 | Comparator: supply below minimum operating level |
| bat_flag_i | input | 1 | Comparator: supply below backup-cell level |
| warn_en_i | input | 1 | Enable for the power-fail interrupt |
| irq_ack_i | input | 1 | Synchronous interrupt acknowledge |
| ext_rst_i | input | 1 | Active-high reset request |
| rst_pin_i | input | 1 | Sensed level of the shared open-drain reset net |
| boot_req_ni | input | 1 | Active-low bootstrap request pin |
| irq_o | output | 1 | Power-fail interrupt request |
| irq_vec_o | output | 16 | Interrupt entry address |
| cpu_rst_o | output | 1 | Processor reset |
| rst_pin_oe_o | output | 1 | 1 pulls the shared reset net low |
| strobe_block_o | output | 1 | 1 forces chip enables and write strobe inactive |
| pwr_fail_no | output | 1 | 0 while running from the backup cell |
| boot_act_o | output | 1 | Qualified bootstrap request level |
| boot_start_o | output | 1 | One-cycle loader start pulse |

## Verification
The assertions take `irq_ack_i` and `warn_en_i` as synchronous to `clk_i`. They take every other input as asynchronous but settled for at least one full clock before it is sampled, so the synchroniser stages never carry metastable values. The stimulus changes inputs only at falling clock edges and holds each level for at least two cycles. It models the reset net as the wired-AND of the block's own pull-down and an external pull-down. This keeps the pin feedback consistent with a real open-drain net.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int unsigned SYNC_W   = 6;
  localparam int unsigned IDX_WARN = 0;
  localparam int unsigned IDX_MIN  = 1;
  localparam int unsigned IDX_BAT  = 2;
  localparam int unsigned IDX_EXT  = 3;
  localparam int unsigned IDX_PIN  = 4;
  localparam int unsigned IDX_BOOT = 5;
  // pins idle high, flags idle low
  localparam logic [SYNC_W-1:0] SYNC_RST = 6'b110000;
  localparam logic [15:0] PF_VECTOR = 16'h002B;
endpackage

// File: rtl/pwr_sync_bank.sv
module pwr_sync_bank #(
  parameter int unsigned        W      = 6,
  parameter int unsigned        STAGES = 2,
  parameter logic [W-1:0]       RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  for (genvar s = 1; s < STAGES; s++) begin : g_chk
    // R1
    stage_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> stg_q[s] == $past(stg_q[s-1]));
  end
endmodule

// File: rtl/pwr_level_filter.sv
module pwr_level_filter #(
  parameter int unsigned HOLD = 48,
  parameter bit          INIT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q, lvl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lvl_q   <= INIT;
      lvl_d_q <= INIT;
    end else begin
      lvl_d_q <= lvl_q;
      if (d_i == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        lvl_q <= d_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;
  assign fall_o  = lvl_d_q & ~lvl_q;

  // R10
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_i == lvl_q) |=> $stable(lvl_q));
  // R10
  filt_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R11
  fall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pwr_por_timer.sv
module pwr_por_timer #(
  parameter int unsigned CYCLES = 21504
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= LOAD;
    else if (hold_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R7
  por_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> busy_o);
  // R7
  por_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POR_CYCLES  = 21504,
  parameter int unsigned BOOT_HOLD   = 48
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        warn_flag_i,
  input  logic        min_flag_i,
  input  logic        bat_flag_i,
  input  logic        warn_en_i,
  input  logic        irq_ack_i,
  input  logic        ext_rst_i,
  input  logic        rst_pin_i,
  input  logic        boot_req_ni,
  output logic        irq_o,
  output logic [15:0] irq_vec_o,
  output logic        cpu_rst_o,
  output logic        rst_pin_oe_o,
  output logic        strobe_block_o,
  output logic        pwr_fail_no,
  output logic        boot_act_o,
  output logic        boot_start_o
);
  logic [SYNC_W-1:0] raw, syn;
  logic warn_s, min_s, bat_s, ext_s, pin_low_s, boot_s;
  logic warn_d_q, irq_q, por_busy, boot_lvl, boot_fall;

  assign raw[IDX_WARN] = warn_flag_i;
  assign raw[IDX_MIN]  = min_flag_i;
  assign raw[IDX_BAT]  = bat_flag_i;
  assign raw[IDX_EXT]  = ext_rst_i;
  assign raw[IDX_PIN]  = rst_pin_i;
  assign raw[IDX_BOOT] = boot_req_ni;

  pwr_sync_bank #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST(SYNC_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  assign warn_s    = syn[IDX_WARN];
  assign min_s     = syn[IDX_MIN];
  assign bat_s     = syn[IDX_BAT];
  assign ext_s     = syn[IDX_EXT];
  assign pin_low_s = ~syn[IDX_PIN];
  assign boot_s    = syn[IDX_BOOT];

  // early warning interrupt: edge-set, ack-clear, set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_d_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      warn_d_q <= warn_s;
      if (warn_s && !warn_d_q && warn_en_i) irq_q <= 1'b1;
      else if (irq_ack_i)                   irq_q <= 1'b0;
    end
  end

  pwr_por_timer #(.CYCLES(POR_CYCLES)) u_por (
    .clk_i, .rst_ni, .hold_i(min_s), .busy_o(por_busy)
  );

  pwr_level_filter #(.HOLD(BOOT_HOLD), .INIT(1'b1)) u_boot (
    .clk_i, .rst_ni, .d_i(boot_s), .level_o(boot_lvl), .fall_o(boot_fall)
  );

  assign irq_o          = irq_q;
  assign irq_vec_o      = PF_VECTOR;
  // only a supply fault drives the net, so an external low cannot latch itself
  assign rst_pin_oe_o   = min_s;
  assign strobe_block_o = min_s;
  assign cpu_rst_o      = min_s | por_busy | ext_s | pin_low_s;
  assign pwr_fail_no    = ~bat_s;
  assign boot_act_o     = ~boot_lvl;
  assign boot_start_o   = boot_fall;

  // R4
  irq_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !(warn_s && !warn_d_q && warn_en_i)) |=> !irq_o);
  // R3
  irq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !warn_en_i) |=> !irq_o);
  // R6
  pin_implies_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_oe_o |-> (cpu_rst_o && strobe_block_o));
  // R8
  ext_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_low_s |-> cpu_rst_o);
  // R11
  boot_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_start_o |-> (boot_act_o && $rose(boot_act_o)));
endmodule

// File: tb/sim_pwr_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_supervisor;
  localparam int POR  = 21504;
  localparam int HOLD = 48;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic warn = 0, minf = 0, bat = 0, en = 0, ack = 0, ext = 0, pull = 0, boot_n = 1;
  logic irq, cpu_rst, oe, blk, pf_n, bact, bstart;
  logic [15:0] vec;
  logic pin;
  int nchk = 0, nfail = 0, cyc = 0;

  always #2.5 clk = ~clk;
  assign pin = ~(oe | pull);

  pwr_supervisor u0 (
    .clk_i(clk), .rst_ni, .warn_flag_i(warn), .min_flag_i(minf), .bat_flag_i(bat),
    .warn_en_i(en), .irq_ack_i(ack), .ext_rst_i(ext), .rst_pin_i(pin),
    .boot_req_ni(boot_n), .irq_o(irq), .irq_vec_o(vec), .cpu_rst_o(cpu_rst),
    .rst_pin_oe_o(oe), .strobe_block_o(blk), .pwr_fail_no(pf_n),
    .boot_act_o(bact), .boot_start_o(bstart)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected <190000", cyc);
      finish_run();
    end
  end

  initial begin
    int pulses;
    step(3);
    // R12 reset state
    chk("R12 cpu_rst", cpu_rst, 1); chk("R12 irq", irq, 0);
    chk("R12 pf_n", pf_n, 1); chk("R12 bact", bact, 0);
    chk("R5 vector", vec, 16'h002B);
    rst_ni = 1'b1;
    step(POR - 1);
    chk("R12 por hold", cpu_rst, 1);
    step(1);
    chk("R12 por release", cpu_rst, 0);

    // R1 R2 backup flag timing
    bat = 1; step(1);
    chk("R1 one edge", pf_n, 1);
    step(1);
    chk("R2 pf low", pf_n, 0);
    bat = 0; step(2);
    chk("R2 pf high", pf_n, 1);

    // R3 enabled warning edge
    en = 1; warn = 1; step(2);
    chk("R3 before", irq, 0);
    step(1);
    chk("R3 set", irq, 1);
    ack = 1; step(1); ack = 0;
    chk("R4 ack clear", irq, 0);
    step(5);
    chk("R3 level no retrigger", irq, 0);
    warn = 0; step(4);
    // R3 disabled
    en = 0; warn = 1; step(4);
    chk("R3 disabled", irq, 0);
    warn = 0; step(4);
    // R4 set wins over simultaneous ack
    en = 1; ack = 1; warn = 1; step(3);
    chk("R4 set wins", irq, 1);
    step(1);
    chk("R4 later ack", irq, 0);
    ack = 0; warn = 0; step(4);

    // R9 external reset input
    ext = 1; step(1);
    chk("R9 pre", cpu_rst, 0);
    step(1);
    chk("R9 held", cpu_rst, 1); chk("R9 no pin", oe, 0);
    ext = 0; step(1);
    chk("R9 still", cpu_rst, 1);
    step(1);
    chk("R9 release", cpu_rst, 0);

    // R8 external pull on shared net
    pull = 1; step(2);
    chk("R8 held", cpu_rst, 1); chk("R8 not driven", oe, 0);
    step(10);
    chk("R8 still", cpu_rst, 1);
    pull = 0; step(1);
    chk("R8 still 1", cpu_rst, 1);
    step(1);
    chk("R8 release", cpu_rst, 0);

    // R6 R7 supply below minimum
    minf = 1; step(2);
    chk("R6 rst", cpu_rst, 1); chk("R6 oe", oe, 1); chk("R6 blk", blk, 1);
    step(20);
    chk("R6 hold", cpu_rst, 1);
    minf = 0; step(2);
    chk("R7 oe drop", oe, 0); chk("R7 blk drop", blk, 0); chk("R7 rst", cpu_rst, 1);
    step(POR - 1);
    chk("R7 last", cpu_rst, 1);
    step(1);
    chk("R7 release", cpu_rst, 0);

    // R10 R11 exact qualification timing
    boot_n = 0; step(HOLD + 1);
    chk("R10 not yet", bact, 0); chk("R11 no pulse", bstart, 0);
    step(1);
    chk("R10 active", bact, 1); chk("R11 pulse", bstart, 1);
    step(1);
    chk("R11 one cycle", bstart, 0);
    boot_n = 1; step(HOLD + 1);
    chk("R10 still active", bact, 1);
    step(1);
    chk("R10 inactive", bact, 0); chk("R11 no rise pulse", bstart, 0);

    // R10 R11 sweep of pulse lengths around the threshold
    for (int len = HOLD - 8; len <= HOLD + 4; len++) begin
      pulses = 0;
      boot_n = 0;
      for (int c = 0; c < len; c++) begin step(1); pulses += bstart; end
      boot_n = 1;
      for (int c = 0; c < 130; c++) begin step(1); pulses += bstart; end
      chk("R10 sweep pulses", pulses, (len >= HOLD) ? 1 : 0);
      chk("R10 sweep idle", bact, 0);
    end

    // R12 async reset mid-run
    en = 1; warn = 1; step(3);
    rst_ni = 0; #1;
    chk("R12 async irq", irq, 0); chk("R12 async rst", cpu_rst, 1);
    finish_run();
  end
endmodule